// File: doc/BRIEF.md
# Paging-Structure Walk Cache

This block sits next to a hardware page walker and remembers where the intermediate paging tables of a four-level, 48-bit virtual address space live in physical memory. Before the walker starts a translation it presents the virtual address on the query port. The block then reports the deepest level it can skip to, together with the physical frame of the table to read next. A hit on a page-directory entry leaves only the final page-table read. A hit on a page-directory-pointer entry leaves two reads, and a hit on a top-level entry leaves three. A miss means the walk starts at the root.

The block holds three independent fully associative tables, one per non-leaf level. The top-level table is keyed on VA[47:39], the pointer-level table on VA[47:30] and the directory-level table on VA[47:21]. The walker writes an entry through the fill port each time it reads a non-leaf paging entry. Entries that are not present, and entries that map a large page, are never kept. Any change to paging memory is handled by pulsing the global flush input, which empties every table. Each table replaces its least recently used entry when it is full.

Top module: `walk_cache`

## Requirements
- R1: After reset, and after any flush, every query reports level 0 (start at root) with base 0.
- R2: A query presented with `q_valid` high in cycle k gives `rsp_valid` high in cycle k+1. `rsp_valid` is low in every cycle that follows a cycle without `q_valid`. While `rsp_valid` is low, `rsp_level` and `rsp_base` are 0.
- R3: `rsp_level` encodes the deepest hit. 3 means a directory-level entry hit and `rsp_base` is the page-table frame. 2 means a pointer-level entry hit and the base is the page-directory frame. 1 means a top-level entry hit and the base is the pointer-table frame. 0 means a miss with base 0. When several tables hit, the highest level wins.
- R4: The top-level table matches on VA[47:39], the pointer-level table on VA[47:30] and the directory-level table on VA[47:21]. Address bits below a table's key never affect whether that table hits.
- R5: A fill with `fill_present` low stores nothing.
- R6: A fill with `fill_large` high at `fill_level` 2 or 3 stores nothing. At `fill_level` 1, `fill_large` is ignored. A fill at `fill_level` 0 stores nothing. A fill at level n (n = 1, 2, 3) is later answered with `rsp_level` n.
- R7: A fill whose key is already held in its table overwrites that entry's base and does not take a second entry.
- R8: A fill of a new key uses the lowest-numbered empty entry. If the table is full, it replaces the entry used least recently, where "used" means stored, refilled, or supplied a query answer.
- R9: A query hit refreshes recency only in the table that supplied the answer. If that same table takes a fill in the same cycle, only the filled entry is refreshed.
- R10: A flush empties all three tables. A fill in the same cycle as a flush is discarded.
- R11: A query presented in the same cycle as a flush reports level 0.
- R12: A query sees the table contents from before any fill in the same cycle. The new entry is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all tables |
| q_valid | input | 1 | Query request |
| q_va | input | VA_W (48) | Query virtual address |
| fill_valid | input | 1 | Fill request |
| fill_level | input | 2 | Level of the entry read: 1 top, 2 pointer, 3 directory |
| fill_va | input | VA_W (48) | Virtual address whose walk produced the entry |
| fill_present | input | 1 | Present bit of the entry read |
| fill_large | input | 1 | Entry maps a large page (leaf) |
| fill_base | input | PA_W-12 (28) | Frame of the next-level table named by the entry |
| rsp_valid | output | 1 | Response valid, one cycle after the query |
| rsp_level | output | 2 | Deepest hit level, 0 for a miss |
| rsp_base | output | PA_W-12 (28) | Frame of the table to read next |

## Verification
The collision that matters is a fill arriving together with a flush. The flush must win, so the filled key must miss afterwards. The bench forces this directly and then queries both the key it tried to fill and keys stored earlier, expecting a miss for all of them. It also places a query in a flush cycle, a query together with a fill of the same key, and a query hit together with a refill in the same table. The random phase raises flushes and fills independently, so these overlaps occur many more times, and each response is judged against a bench model that applies flush first, then the fill, then the query's recency update.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int NUM_TBL   = 3;
    localparam int IDX_BITS  = 9;
    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        LV_ROOT = 2'd0,
        LV_DPT  = 2'd1,
        LV_DIR  = 2'd2,
        LV_TBL  = 2'd3
    } wc_level_e;

    // Lowest virtual address bit of the key for table t (0 top, 1 pointer, 2 directory)
    function automatic int key_lsb(input int t);
        return PAGE_BITS + IDX_BITS * (NUM_TBL - t);
    endfunction
endpackage

// File: rtl/wc_table.sv
module wc_table #(
    parameter int KEY_W   = 9,
    parameter int ENTRIES = 4,
    parameter int BASE_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              lk_hit,
    output logic [BASE_W-1:0] lk_base,
    input  logic              lk_touch,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [BASE_W-1:0] wr_base
);
    localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][KEY_W-1:0]  key;
        logic [ENTRIES-1:0][BASE_W-1:0] base;
        logic [ENTRIES-1:0][AGE_W-1:0]  age;
    } tbl_t;

    tbl_t st_q, st_d;

    logic [AGE_W-1:0] lk_idx, wr_idx, vic_idx, tgt_idx;
    logic             wr_hit, tgt_en;

    function automatic tbl_t idle_state();
        tbl_t s;
        s = '0;
        for (int i = 0; i < ENTRIES; i++) s.age[i] = AGE_W'(i);
        return s;
    endfunction

    always_comb begin
        lk_hit  = 1'b0;
        lk_idx  = '0;
        wr_hit  = 1'b0;
        wr_idx  = '0;
        vic_idx = '0;
        // oldest entry first, then any empty slot overrides (lowest index wins)
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (st_q.age[i] == AGE_OLDEST) vic_idx = AGE_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) vic_idx = AGE_W'(i);
            if (st_q.vld[i] && st_q.key[i] == lk_key) begin
                lk_hit = 1'b1;
                lk_idx = AGE_W'(i);
            end
            if (st_q.vld[i] && st_q.key[i] == wr_key) begin
                wr_hit = 1'b1;
                wr_idx = AGE_W'(i);
            end
        end
        lk_base = lk_hit ? st_q.base[lk_idx] : '0;

        if (wr_en) begin
            tgt_en  = 1'b1;
            tgt_idx = wr_hit ? wr_idx : vic_idx;
        end else begin
            tgt_en  = lk_touch && lk_hit;
            tgt_idx = lk_idx;
        end

        st_d = st_q;
        if (wr_en) begin
            st_d.vld[tgt_idx]  = 1'b1;
            st_d.key[tgt_idx]  = wr_key;
            st_d.base[tgt_idx] = wr_base;
        end
        if (tgt_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.age[i] < st_q.age[tgt_idx]) st_d.age[i] = st_q.age[i] + 1'b1;
            end
            st_d.age[tgt_idx] = '0;
        end
        if (flush) st_d = idle_state();
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= idle_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wc_fill_dec.sv
module wc_fill_dec
    import wc_pkg::*;
(
    input  logic               fill_valid,
    input  logic               fill_present,
    input  logic               fill_large,
    input  logic [1:0]         fill_level,
    input  logic               flush,
    output logic [NUM_TBL-1:0] wr_en
);
    logic accept;

    always_comb begin
        accept = fill_valid && fill_present && !flush;
        for (int t = 0; t < NUM_TBL; t++) begin
            // large-page entries below the top level are leaves: never kept
            wr_en[t] = accept && (fill_level == 2'(t + 1)) && !(fill_large && t > 0);
        end
    end
endmodule

// File: rtl/wc_pick.sv
module wc_pick
    import wc_pkg::*;
#(
    parameter int BASE_W = 28
) (
    input  logic [NUM_TBL-1:0]             hit,
    input  logic [NUM_TBL-1:0][BASE_W-1:0] base,
    output logic [1:0]                     level,
    output logic [BASE_W-1:0]              sel_base,
    output logic [NUM_TBL-1:0]             sel
);
    always_comb begin
        level    = LV_ROOT;
        sel_base = '0;
        sel      = '0;
        // ascending scan: the deepest table that hits is kept
        for (int t = 0; t < NUM_TBL; t++) begin
            if (hit[t]) begin
                level    = 2'(t + 1);
                sel_base = base[t];
                sel      = NUM_TBL'(1) << t;
            end
        end
    end
endmodule

// File: rtl/walk_cache.sv
module walk_cache
    import wc_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int PA_W  = 40,
    parameter int N_TOP = 4,
    parameter int N_DPT = 4,
    parameter int N_DIR = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      q_valid,
    input  logic [VA_W-1:0]           q_va,
    input  logic                      fill_valid,
    input  logic [1:0]                fill_level,
    input  logic [VA_W-1:0]           fill_va,
    input  logic                      fill_present,
    input  logic                      fill_large,
    input  logic [PA_W-PAGE_BITS-1:0] fill_base,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_level,
    output logic [PA_W-PAGE_BITS-1:0] rsp_base
);
    localparam int BASE_W  = PA_W - PAGE_BITS;
    localparam int MIN_LSB = key_lsb(NUM_TBL - 1);

    typedef struct packed {
        logic              valid;
        logic [1:0]        level;
        logic [BASE_W-1:0] base;
    } rsp_t;

    rsp_t rsp_q, rsp_d;

    logic [NUM_TBL-1:0]             hit, wr_en, sel;
    logic [NUM_TBL-1:0][BASE_W-1:0] hbase;
    logic [1:0]                     pick_level;
    logic [BASE_W-1:0]              pick_base;
    logic                           unused_low;

    assign unused_low = ^{q_va[MIN_LSB-1:0], fill_va[MIN_LSB-1:0]};

    wc_fill_dec u_dec (
        .fill_valid   (fill_valid),
        .fill_present (fill_present),
        .fill_large   (fill_large),
        .fill_level   (fill_level),
        .flush        (flush),
        .wr_en        (wr_en)
    );

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        localparam int LSB = key_lsb(t);
        localparam int NE  = (t == 0) ? N_TOP : (t == 1) ? N_DPT : N_DIR;
        logic touch;
        assign touch = q_valid && !flush && sel[t] && !wr_en[t];

        wc_table #(
            .KEY_W   (VA_W - LSB),
            .ENTRIES (NE),
            .BASE_W  (BASE_W)
        ) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .lk_key   (q_va[VA_W-1:LSB]),
            .lk_hit   (hit[t]),
            .lk_base  (hbase[t]),
            .lk_touch (touch),
            .wr_en    (wr_en[t]),
            .wr_key   (fill_va[VA_W-1:LSB]),
            .wr_base  (fill_base)
        );
    end

    wc_pick #(.BASE_W(BASE_W)) u_pick (
        .hit      (hit),
        .base     (hbase),
        .level    (pick_level),
        .sel_base (pick_base),
        .sel      (sel)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = q_valid;
        if (q_valid && !flush) begin
            rsp_d.level = pick_level;
            rsp_d.base  = pick_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_level = rsp_q.level;
    assign rsp_base  = rsp_q.base;
endmodule

// File: rtl/walk_cache_chk.sv
module walk_cache_chk #(
    parameter int BASE_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              q_valid,
    input logic              fill_valid,
    input logic [1:0]        fill_level,
    input logic              fill_present,
    input logic              fill_large,
    input logic              rsp_valid,
    input logic [1:0]        rsp_level,
    input logic [BASE_W-1:0] rsp_base
);
    p_rsp_follows_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> rsp_valid);

    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> (!rsp_valid && rsp_level == 2'd0 && rsp_base == '0));

    p_miss_zero_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_level == 2'd0) |-> rsp_base == '0);

    p_flush_query_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && flush) |=> rsp_level == 2'd0);

    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush, 2) && $past(q_valid)) |-> rsp_level == 2'd0);

    p_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush, 3) && $past(fill_valid && !fill_present, 2) && $past(q_valid))
        |-> rsp_level == 2'd0);

    p_leaf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush, 3) && $past(fill_valid && fill_large && fill_level >= 2'd2, 2)
         && $past(q_valid)) |-> rsp_level == 2'd0);
endmodule

bind walk_cache walk_cache_chk #(.BASE_W(BASE_W)) u_chk (.*);

// File: tb/walk_cache_test.sv
`timescale 1ns/1ps
module walk_cache_test;
    localparam int BW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          q_valid = 1'b0;
    logic [47:0]   q_va = '0;
    logic          fill_valid = 1'b0;
    logic [1:0]    fill_level = '0;
    logic [47:0]   fill_va = '0;
    logic          fill_present = 1'b0;
    logic          fill_large = 1'b0;
    logic [BW-1:0] fill_base = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_level;
    logic [BW-1:0] rsp_base;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    walk_cache uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q_valid(q_valid), .q_va(q_va),
        .fill_valid(fill_valid), .fill_level(fill_level), .fill_va(fill_va),
        .fill_present(fill_present), .fill_large(fill_large), .fill_base(fill_base),
        .rsp_valid(rsp_valid), .rsp_level(rsp_level), .rsp_base(rsp_base)
    );

    // reference model: three tables, sizes 4 / 4 / 8
    int            mn[3] = '{4, 4, 8};
    logic          mv[3][8];
    logic [26:0]   mk[3][8];
    logic [BW-1:0] mb[3][8];
    int            ma[3][8];

    function automatic logic [26:0] mkey(input int t, input logic [47:0] va);
        return 27'(va >> (39 - 9 * t));
    endfunction

    function automatic logic [47:0] mva(input int a, input int b, input int c, input int lo);
        return {9'(a), 9'(b), 9'(c), 21'(lo)};
    endfunction

    task automatic m_clear();
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < 8; i++) begin
                mv[t][i] = 1'b0; mk[t][i] = '0; mb[t][i] = '0; ma[t][i] = i;
            end
    endtask

    function automatic int m_find(input int t, input logic [26:0] k);
        for (int i = 0; i < mn[t]; i++) if (mv[t][i] && mk[t][i] == k) return i;
        return -1;
    endfunction

    function automatic int m_victim(input int t);
        for (int i = 0; i < mn[t]; i++) if (!mv[t][i]) return i;
        for (int i = 0; i < mn[t]; i++) if (ma[t][i] == mn[t] - 1) return i;
        return 0;
    endfunction

    task automatic m_touch(input int t, input int idx);
        int a;
        a = ma[t][idx];
        for (int j = 0; j < mn[t]; j++) if (ma[t][j] < a) ma[t][j] = ma[t][j] + 1;
        ma[t][idx] = 0;
    endtask

    task automatic fail(input string tag, input string what, input int act, input int exp);
        n_errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // one cycle: drive, predict, then sample 1 ns after the edge
    task automatic step(input logic qv, input logic [47:0] qva,
                        input logic fv, input logic [1:0] fl, input logic [47:0] fva,
                        input logic fp, input logic flg, input logic [BW-1:0] fb,
                        input logic fx, input string tag, input int want = -1);
        int el, ht, hi, wt, wi;
        logic [BW-1:0] eb;
        @(negedge clk);
        q_valid = qv; q_va = qva; fill_valid = fv; fill_level = fl; fill_va = fva;
        fill_present = fp; fill_large = flg; fill_base = fb; flush = fx;
        el = 0; eb = '0; ht = -1; hi = -1; wt = -1;
        if (qv && !fx)
            for (int t = 2; t >= 0 && ht < 0; t--) begin
                wi = m_find(t, mkey(t, qva));
                if (wi >= 0) begin el = t + 1; eb = mb[t][wi]; ht = t; hi = wi; end
            end
        if (fx) m_clear();
        else begin
            if (fv && fp && fl != 2'd0 && !(flg && fl >= 2'd2)) begin
                wt = int'(fl) - 1;
                wi = m_find(wt, mkey(wt, fva));
                if (wi < 0) wi = m_victim(wt);
                mv[wt][wi] = 1'b1; mk[wt][wi] = mkey(wt, fva); mb[wt][wi] = fb;
                m_touch(wt, wi);
            end
            if (ht >= 0 && ht != wt) m_touch(ht, hi);
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (rsp_valid !== qv) fail(tag, "rsp_valid", int'(rsp_valid), int'(qv));
        else if (rsp_level !== 2'(el)) fail(tag, "rsp_level", int'(rsp_level), el);
        else if (rsp_base !== eb) fail(tag, "rsp_base", int'(rsp_base), int'(eb));
        if (want >= 0) begin
            n_checks++;
            if (rsp_level !== 2'(want)) fail(tag, "directed level", int'(rsp_level), want);
        end
    endtask

    task automatic query(input logic [47:0] va, input string tag, input int want = -1);
        step(1'b1, va, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b0, tag, want);
    endtask

    task automatic fill(input int lvl, input logic [47:0] va, input logic [BW-1:0] b, input string tag);
        step(1'b0, '0, 1'b1, 2'(lvl), va, 1'b1, 1'b0, b, 1'b0, tag);
    endtask

    task automatic flush_only();
        step(1'b0, '0, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R2 actual=hang expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        m_clear();
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_level !== 2'd0) fail("R1", "reset state", int'(rsp_level), 0);
        @(negedge clk);
        rst_n = 1'b1;

        query(mva(1, 1, 1, 0), "R1 empty after reset", 0);
        fill(1, mva(1, 0, 0, 0), 28'h100, "R3");
        query(mva(1, 7, 7, 5), "R4 top key ignores low bits", 1);
        fill(2, mva(1, 2, 0, 0), 28'h200, "R3");
        fill(3, mva(1, 2, 3, 0), 28'h300, "R3");
        query(mva(1, 2, 3, 999), "R3 deepest level", 3);
        query(mva(1, 2, 4, 0), "R3 R4 same 1GiB region", 2);
        step(1'b0, '0, 1'b1, 2'd3, mva(1, 2, 5, 0), 1'b0, 1'b0, 28'h777, 1'b0, "R5");
        query(mva(1, 2, 5, 0), "R5 absent entry not kept", 2);
        step(1'b0, '0, 1'b1, 2'd2, mva(1, 6, 0, 0), 1'b1, 1'b1, 28'h666, 1'b0, "R6");
        query(mva(1, 6, 0, 0), "R6 large pointer entry not kept", 1);
        step(1'b0, '0, 1'b1, 2'd3, mva(1, 2, 6, 0), 1'b1, 1'b1, 28'h555, 1'b0, "R6");
        query(mva(1, 2, 6, 0), "R6 large directory entry not kept", 2);
        step(1'b0, '0, 1'b1, 2'd1, mva(9, 0, 0, 0), 1'b1, 1'b1, 28'h900, 1'b0, "R6");
        query(mva(9, 0, 0, 0), "R6 large flag ignored at top", 1);
        step(1'b0, '0, 1'b1, 2'd0, mva(8, 0, 0, 0), 1'b1, 1'b0, 28'h800, 1'b0, "R6");
        query(mva(8, 0, 0, 0), "R6 level 0 fill ignored", 0);
        fill(1, mva(1, 0, 0, 0), 28'h111, "R7");
        query(mva(1, 0, 0, 0), "R7 refill overwrites base", 1);
        step(1'b1, mva(3, 0, 0, 0), 1'b1, 2'd1, mva(3, 0, 0, 0), 1'b1, 1'b0, 28'h333, 1'b0,
             "R12 query sees old contents", 0);
        query(mva(3, 0, 0, 0), "R12 fill visible next cycle", 1);
        step(1'b0, '0, 1'b1, 2'd1, mva(4, 0, 0, 0), 1'b1, 1'b0, 28'h444, 1'b1, "R10");
        query(mva(4, 0, 0, 0), "R10 flush beats fill", 0);
        query(mva(1, 2, 3, 0), "R10 flush empties all", 0);
        fill(1, mva(5, 0, 0, 0), 28'h500, "R11");
        step(1'b1, mva(5, 0, 0, 0), 1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, "R11 query during flush", 0);
        query(mva(5, 0, 0, 0), "R1 empty after flush", 0);

        for (int k = 10; k < 14; k++) fill(1, mva(k, 0, 0, 0), BW'(k), "R8");
        query(mva(10, 0, 0, 0), "R9 hit refreshes", 1);
        fill(1, mva(14, 0, 0, 0), 28'd14, "R8");
        query(mva(11, 0, 0, 0), "R8 oldest evicted", 0);
        query(mva(10, 0, 0, 0), "R8 refreshed entry kept", 1);

        flush_only();
        for (int k = 20; k < 24; k++) fill(1, mva(k, 0, 0, 0), BW'(k), "R8");
        step(1'b1, mva(20, 0, 0, 0), 1'b1, 2'd1, mva(23, 0, 0, 0), 1'b1, 1'b0, 28'h23,
             1'b0, "R9 hit with same-table refill", 1);
        fill(1, mva(24, 0, 0, 0), 28'd24, "R9");
        query(mva(20, 0, 0, 0), "R9 query refresh suppressed", 0);
        step(1'b1, mva(21, 0, 0, 0), 1'b1, 2'd2, mva(30, 1, 0, 0), 1'b1, 1'b0, 28'h31,
             1'b0, "R9 hit with other-table fill", 1);
        fill(1, mva(25, 0, 0, 0), 28'd25, "R9");
        query(mva(21, 0, 0, 0), "R9 refreshed in answering table", 1);
        query(mva(22, 0, 0, 0), "R8 next oldest evicted", 0);

        for (int n = 0; n < 3000; n++) begin
            logic qv, fv, fp, flg, fx;
            logic [1:0] fl;
            logic [47:0] qa, fa;
            qv  = ($urandom % 4) != 0;
            fv  = ($urandom % 2) != 0;
            fp  = ($urandom % 8) != 0;
            flg = ($urandom % 8) == 0;
            fx  = ($urandom % 64) == 0;
            fl  = 2'($urandom % 4);
            qa  = mva($urandom % 5, $urandom % 2, $urandom % 2, $urandom);
            fa  = mva($urandom % 5, $urandom % 2, $urandom % 2, $urandom);
            step(qv, qa, fv, fl, fa, fp, flg, BW'($urandom), fx, "R3 R8 R9 R10 R12 random");
        end

        @(negedge clk);
        q_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule